// File: doc/BRIEF.md
# Error Interrupt Aggregator

This block gathers level-sensitive error lines from a set of protection units and folds them into one interrupt per destination core. Address errors and protection errors travel separate paths. For every core and every error type there are three registers: a mask that chooses which units may raise that core's interrupt, a sticky raw record of every unit that has signalled, and a sticky masked status that drives the interrupt.

Both sticky registers are cleared by writing ones. A bit whose source line is still high when the clear lands stays set, because the set takes priority. Software therefore has to clear the error at the unit first and the aggregated bit second. A second pair of outputs, one per error type, feeds a safety error monitor. It has its own two mask words: one for address errors and one for protection errors.

Register access is a single-cycle write strobe with a combinational read. Word addresses are `core*8 + type*4 + kind`, where type 0 is address and type 1 is protection, and kind 0 is mask, 1 is status and 2 is raw. The safety mask words sit at `NUM_CORE*8` (address) and `NUM_CORE*8+1` (protection).

Top module: `err_irq_aggregator`

## Requirements
- R1: After reset every mask, status and raw register reads zero and every interrupt output is low.
- R2: A raw bit is set at the first clock edge at which its source line is high, whatever the mask holds, and it stays set after the source drops.
- R3: A status bit is set only at an edge where its source is high and the matching bit of that core's mask for that error type is one. With the mask bit at zero, status stays zero and no interrupt is raised.
- R4: A core interrupt output is the OR of that core's status bits for that error type, one cycle later. It rises at the second edge after the source rises and falls one edge after the last status bit clears.
- R5: Address and protection paths are independent, and so are the register sets of different cores. A source or mask on one path never sets status or raises an interrupt on another.
- R6: Writing to a status word clears every bit written as one, provided its source is low or unmasked, and leaves bits written as zero unchanged. Raw is untouched.
- R7: Writing to a raw word clears every bit written as one, provided its source is low. Status is untouched.
- R8: When a clear of a status or raw bit lands at an edge where that bit would be set, the bit stays set.
- R9: The safety outputs are the OR of each error type's source lines ANDed with that type's safety mask word, registered once. The address word is at NUM_CORE*8 and the protection word at NUM_CORE*8+1.
- R10: Reads return register bits NUM_SRC-1..0 with the upper bits zero. Unmapped addresses read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_err_i | input | NUM_SRC | Address-error level per source unit |
| prot_err_i | input | NUM_SRC | Protection-error level per source unit |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| core_addr_irq_o | output | NUM_CORE | Aggregated address-error interrupt per core |
| core_prot_irq_o | output | NUM_CORE | Aggregated protection-error interrupt per core |
| safe_addr_err_o | output | 1 | Aggregated address error to the safety monitor |
| safe_prot_err_o | output | 1 | Aggregated protection error to the safety monitor |

## Verification
The bench first raises a source with its mask bit clear, which separates the raw record from the masked status. It then raises a masked source on a single core and a single type; this exposes crossed paths and gets the two-edge interrupt latency right. Clears are issued both with the source held high and after it drops, which distinguishes set priority from a plain clear, and raw and status are cleared separately to show that each clear leaves the other register alone. Sources are then driven inside and outside the safety mask words, together with reads of unmapped and oversized words, to check the safety path and the decode.

// File: rtl/errag_pkg.sv
package errag_pkg;
    localparam int TYPE_ADDR   = 0;
    localparam int TYPE_PROT   = 1;
    localparam int NUM_TYPE    = 2;
    localparam int CORE_STRIDE = 8;
    localparam int TYPE_STRIDE = 4;

    typedef enum logic [1:0] {
        KIND_MASK = 2'd0,
        KIND_STAT = 2'd1,
        KIND_RAW  = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/errag_lane.sv
module errag_lane #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic               wr_mask,
    input  logic               wr_stat,
    input  logic               wr_raw,
    input  logic [NUM_SRC-1:0] wbits,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] stat_q,
    output logic [NUM_SRC-1:0] raw_q,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] stat_clr;
    logic [NUM_SRC-1:0] raw_clr;
    logic [NUM_SRC-1:0] stat_set;

    assign stat_clr = wr_stat ? wbits : '0;
    assign raw_clr  = wr_raw  ? wbits : '0;
    assign stat_set = src & mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            stat_q <= '0;
            raw_q  <= '0;
            irq_o  <= 1'b0;
        end else begin
            if (wr_mask) begin
                mask_q <= wbits;
            end
            raw_q  <= (raw_q & ~raw_clr) | src;
            stat_q <= (stat_q & ~stat_clr) | stat_set;
            irq_o  <= |stat_q;
        end
    end

    assert_raw_tracks_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & $past(src)) == $past(src)));

    assert_stat_needs_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(mask_q)) == '0));

    assert_irq_from_stat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(stat_q) != '0));

    assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((stat_q & $past(wbits & ~(src & mask_q))) == '0));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(src & mask_q)) == $past(src & mask_q)));
endmodule

// File: rtl/errag_safe_path.sv
module errag_safe_path #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic               wr_mask,
    input  logic [NUM_SRC-1:0] wbits,
    output logic [NUM_SRC-1:0] mask_q,
    output logic               err_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            err_o  <= 1'b0;
        end else begin
            if (wr_mask) begin
                mask_q <= wbits;
            end
            err_o <= |(src & mask_q);
        end
    end

    assert_safe_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> ($past(src & mask_q) != '0));

    assert_safe_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src & mask_q) == '0) |-> !err_o);
endmodule

// File: rtl/err_irq_aggregator.sv
module err_irq_aggregator
    import errag_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int NUM_CORE = 2,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  addr_err_i,
    input  logic [NUM_SRC-1:0]  prot_err_i,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NUM_CORE-1:0] core_addr_irq_o,
    output logic [NUM_CORE-1:0] core_prot_irq_o,
    output logic                safe_addr_err_o,
    output logic                safe_prot_err_o
);
    localparam int SAFE_BASE = NUM_CORE * CORE_STRIDE;

    logic [NUM_SRC-1:0] wbits;
    logic               unused_wdata;
    logic [NUM_SRC-1:0] src_by_type [NUM_TYPE];

    logic [NUM_SRC-1:0] mask_a [NUM_CORE][NUM_TYPE];
    logic [NUM_SRC-1:0] stat_a [NUM_CORE][NUM_TYPE];
    logic [NUM_SRC-1:0] raw_a  [NUM_CORE][NUM_TYPE];
    logic               irq_a  [NUM_CORE][NUM_TYPE];
    logic [NUM_SRC-1:0] safe_mask_a [NUM_TYPE];
    logic               safe_err_a  [NUM_TYPE];

    assign wbits        = reg_wdata[NUM_SRC-1:0];
    assign unused_wdata = ^reg_wdata;
    assign src_by_type[TYPE_ADDR] = addr_err_i;
    assign src_by_type[TYPE_PROT] = prot_err_i;

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        for (genvar t = 0; t < NUM_TYPE; t++) begin : g_type
            localparam logic [ADDR_W-1:0] BASE =
                ADDR_W'(c * CORE_STRIDE + t * TYPE_STRIDE);

            errag_lane #(.NUM_SRC(NUM_SRC)) lane_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .src     (src_by_type[t]),
                .wr_mask (reg_we && reg_addr == BASE + ADDR_W'(KIND_MASK)),
                .wr_stat (reg_we && reg_addr == BASE + ADDR_W'(KIND_STAT)),
                .wr_raw  (reg_we && reg_addr == BASE + ADDR_W'(KIND_RAW)),
                .wbits   (wbits),
                .mask_q  (mask_a[c][t]),
                .stat_q  (stat_a[c][t]),
                .raw_q   (raw_a[c][t]),
                .irq_o   (irq_a[c][t])
            );
        end
        assign core_addr_irq_o[c] = irq_a[c][TYPE_ADDR];
        assign core_prot_irq_o[c] = irq_a[c][TYPE_PROT];
    end

    for (genvar t = 0; t < NUM_TYPE; t++) begin : g_safe
        localparam logic [ADDR_W-1:0] SAFE_ADDR = ADDR_W'(SAFE_BASE + t);

        errag_safe_path #(.NUM_SRC(NUM_SRC)) safe_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (src_by_type[t]),
            .wr_mask (reg_we && reg_addr == SAFE_ADDR),
            .wbits   (wbits),
            .mask_q  (safe_mask_a[t]),
            .err_o   (safe_err_a[t])
        );
    end

    assign safe_addr_err_o = safe_err_a[TYPE_ADDR];
    assign safe_prot_err_o = safe_err_a[TYPE_PROT];

    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CORE; c++) begin
            for (int t = 0; t < NUM_TYPE; t++) begin
                if (reg_addr == ADDR_W'(c * CORE_STRIDE + t * TYPE_STRIDE + int'(KIND_MASK)))
                    reg_rdata[NUM_SRC-1:0] = mask_a[c][t];
                if (reg_addr == ADDR_W'(c * CORE_STRIDE + t * TYPE_STRIDE + int'(KIND_STAT)))
                    reg_rdata[NUM_SRC-1:0] = stat_a[c][t];
                if (reg_addr == ADDR_W'(c * CORE_STRIDE + t * TYPE_STRIDE + int'(KIND_RAW)))
                    reg_rdata[NUM_SRC-1:0] = raw_a[c][t];
            end
        end
        for (int t = 0; t < NUM_TYPE; t++) begin
            if (reg_addr == ADDR_W'(SAFE_BASE + t))
                reg_rdata[NUM_SRC-1:0] = safe_mask_a[t];
        end
    end

    assert_irq_low_in_reset_R1: assert property (@(posedge clk)
        !rst_n |-> (core_addr_irq_o == '0 && core_prot_irq_o == '0));
endmodule

// File: tb/err_irq_aggregator_tb_top.sv
module err_irq_aggregator_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] addr_err_i = '0;
    logic [NS-1:0] prot_err_i = '0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NC-1:0] core_addr_irq_o, core_prot_irq_o;
    logic          safe_addr_err_o, safe_prot_err_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    err_irq_aggregator #(.NUM_SRC(NS), .NUM_CORE(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_err_i(addr_err_i), .prot_err_i(prot_err_i),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .core_addr_irq_o(core_addr_irq_o), .core_prot_irq_o(core_prot_irq_o),
        .safe_addr_err_o(safe_addr_err_o), .safe_prot_err_o(safe_prot_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // address = core*8 + type*4 + kind ; kind 0 mask, 1 status, 2 raw
    function automatic logic [7:0] ra(input int core, input int typ, input int kind);
        return 8'(core * 8 + typ * 4 + kind);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 18; a++) begin
            rd(8'(a), d);
            chk($sformatf("R1 reg %0d after reset", a), d, 32'h0);
        end
        chk("R1 irq outputs after reset",
            {28'h0, core_addr_irq_o, core_prot_irq_o}, 32'h0);
        chk("R1 safety outputs after reset", {30'h0, safe_addr_err_o, safe_prot_err_o}, 32'h0);
    endtask

    task automatic t_raw_unmasked();
        logic [31:0] d;
        addr_err_i = 8'h08;
        step(1);
        rd(ra(0, 0, 2), d); chk("R2 raw core0 addr set", d, 32'h08);
        rd(ra(1, 0, 2), d); chk("R2 raw core1 addr set", d, 32'h08);
        rd(ra(0, 1, 2), d); chk("R5 raw core0 prot untouched", d, 32'h0);
        rd(ra(0, 0, 1), d); chk("R3 status stays zero unmasked", d, 32'h0);
        addr_err_i = 8'h00;
        step(2);
        chk("R3 no irq when unmasked", {30'h0, core_addr_irq_o}, 32'h0);
        rd(ra(0, 0, 2), d); chk("R2 raw sticky after source drop", d, 32'h08);
        wr(ra(0, 0, 2), 32'h0000_00FF);
        wr(ra(1, 0, 2), 32'h0000_00FF);
        rd(ra(0, 0, 2), d); chk("R7 raw core0 cleared", d, 32'h0);
        rd(ra(1, 0, 2), d); chk("R7 raw core1 cleared", d, 32'h0);
    endtask

    task automatic t_masked_irq();
        logic [31:0] d;
        wr(ra(0, 0, 0), 32'h0C);
        addr_err_i = 8'h04;
        step(1);
        rd(ra(0, 0, 1), d); chk("R3 status core0 addr set", d, 32'h04);
        chk("R4 irq not yet risen", {31'h0, core_addr_irq_o[0]}, 32'h0);
        step(1);
        chk("R4 irq risen after second edge", {31'h0, core_addr_irq_o[0]}, 32'h1);
        chk("R5 core1 addr irq low", {31'h0, core_addr_irq_o[1]}, 32'h0);
        chk("R5 prot irqs low", {30'h0, core_prot_irq_o}, 32'h0);
        rd(ra(1, 0, 1), d); chk("R5 core1 status zero", d, 32'h0);
        addr_err_i = 8'h00;
        step(1);
        wr(ra(0, 0, 1), 32'h00);
        rd(ra(0, 0, 1), d); chk("R6 zero write leaves status", d, 32'h04);
        wr(ra(0, 0, 2), 32'h04);
        rd(ra(0, 0, 2), d); chk("R7 raw cleared", d, 32'h0);
        rd(ra(0, 0, 1), d); chk("R7 status untouched by raw clear", d, 32'h04);
        chk("R7 irq still high", {31'h0, core_addr_irq_o[0]}, 32'h1);
        addr_err_i = 8'h04;
        step(1);
        addr_err_i = 8'h00;
        step(1);
        wr(ra(0, 0, 1), 32'h04);
        rd(ra(0, 0, 1), d); chk("R6 status cleared", d, 32'h0);
        rd(ra(0, 0, 2), d); chk("R6 raw untouched by status clear", d, 32'h04);
        chk("R4 irq holds one edge after clear", {31'h0, core_addr_irq_o[0]}, 32'h1);
        step(1);
        chk("R4 irq falls after clear", {31'h0, core_addr_irq_o[0]}, 32'h0);
        wr(ra(0, 0, 2), 32'h04);
    endtask

    task automatic t_set_dominates();
        logic [31:0] d;
        wr(ra(1, 1, 0), 32'h01);
        prot_err_i = 8'h01;
        step(2);
        chk("R4 core1 prot irq high", {31'h0, core_prot_irq_o[1]}, 32'h1);
        chk("R5 core0 prot irq low", {31'h0, core_prot_irq_o[0]}, 32'h0);
        wr(ra(1, 1, 1), 32'h01);
        rd(ra(1, 1, 1), d); chk("R8 status clear blocked by live source", d, 32'h01);
        wr(ra(1, 1, 2), 32'h01);
        rd(ra(1, 1, 2), d); chk("R8 raw clear blocked by live source", d, 32'h01);
        prot_err_i = 8'h00;
        wr(ra(1, 1, 1), 32'h01);
        rd(ra(1, 1, 1), d); chk("R6 status cleared after source drop", d, 32'h0);
        wr(ra(1, 1, 2), 32'h01);
        rd(ra(1, 1, 2), d); chk("R7 raw cleared after source drop", d, 32'h0);
        rd(ra(0, 1, 2), d);
        wr(ra(0, 1, 2), 32'hFF);
        step(1);
        chk("R4 core1 prot irq low after clear", {31'h0, core_prot_irq_o[1]}, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(ra(0, 1, 0), 32'hFFFF_FFFF);
        rd(ra(0, 1, 0), d); chk("R10 upper bits read zero", d, 32'h0000_00FF);
        wr(8'd3, 32'hFFFF_FFFF);
        rd(8'd3, d); chk("R10 unmapped kind reads zero", d, 32'h0);
        rd(8'd40, d); chk("R10 unmapped high address reads zero", d, 32'h0);
        rd(ra(0, 1, 1), d); chk("R10 write to unmapped left status", d, 32'h0);
        wr(ra(0, 1, 0), 32'h0);
    endtask

    task automatic t_safety();
        wr(8'd16, 32'h80);
        wr(8'd17, 32'h02);
        addr_err_i = 8'h80;
        step(1);
        chk("R9 safety addr raised", {31'h0, safe_addr_err_o}, 32'h1);
        chk("R9 safety prot quiet", {31'h0, safe_prot_err_o}, 32'h0);
        addr_err_i = 8'h40;
        prot_err_i = 8'h01;
        step(1);
        chk("R9 safety addr masked source", {31'h0, safe_addr_err_o}, 32'h0);
        chk("R9 safety prot masked source", {31'h0, safe_prot_err_o}, 32'h0);
        prot_err_i = 8'h02;
        step(1);
        chk("R9 safety prot raised", {31'h0, safe_prot_err_o}, 32'h1);
        addr_err_i = 8'h00;
        prot_err_i = 8'h00;
        step(1);
        chk("R9 safety outputs drop", {30'h0, safe_addr_err_o, safe_prot_err_o}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_raw_unmasked();
        t_masked_irq();
        t_set_dominates();
        t_map();
        t_safety();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule